// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for a four-beat memory burst. A full start address is captured whenever either of two active-low address strobes is low at a clock edge. After that, each clock with the active-low step input low moves the two least significant address bits to the next beat. The upper bits keep the captured value for the whole burst.

A static mode input picks how the low bits move. In linear mode they count upward modulo four from the captured start. In interleaved mode they are the captured start bits XOR the beat count. The address output and a beat index are both registered. A memory controller or a bus bridge can drive its array address straight from them.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, `addr_out` is 0 and `beat_idx` is 0.
- R2: At a clock edge where `strb_a_n` or `strb_b_n` is low, `addr_out` takes `addr_in` and `beat_idx` becomes 0. Either strobe alone is enough.
- R3: While the block is stepping or holding, `addr_out[ADDR_W-1:2]` keeps the value captured at the last load.
- R4: With `linear_n` = 0 (linear mode), the low two bits of `addr_out` are (start + `beat_idx`) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: With `linear_n` = 1 (interleaved mode, the default), the low two bits of `addr_out` are start XOR `beat_idx`. For example, a start of 10 gives 10, 11, 00, 01.
- R6: At an edge with both strobes high and `adv_n` high, `addr_out` and `beat_idx` keep their values (suspend).
- R7: At an edge with both strobes high and `adv_n` low, `beat_idx` increments modulo 4. The fourth step returns the address to the captured start.
- R8: When a strobe and `adv_n` are both low at the same edge, the load wins. A load in the middle of a burst restarts the sequence from the new address at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_a_n | input | 1 | Address strobe A, active low |
| strb_b_n | input | 1 | Address strobe B, active low |
| adv_n | input | 1 | Step to the next beat, active low |
| linear_n | input | 1 | Order select: 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | Start address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address, registered |
| beat_idx | output | 2 | Beats stepped since the last load, registered |

## Verification
Every result is due exactly one clock after the edge that samples its control inputs. A load, a step or a hold applied before edge N shows on `addr_out` and `beat_idx` after edge N, and stays there until edge N+1.

The driver applies inputs on the falling edge. For each cycle it pushes one expected address/beat pair, computed from its own model of the start bits and the beat count. The monitor pops one pair two time units after each rising edge and compares it with the outputs. Expected values therefore line up with the single register stage.

The sequence covers all four start values in both orders. It also includes suspends inside bursts, wraps past the fourth beat, loads that collide with a step, and a reload in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int W = 2
) (
  input  order_e         order,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   idx,
  output logic [W-1:0]   low
);
  always_comb begin
    case (order)
      ORD_LINEAR: low = base + idx;
      default:    low = base ^ idx;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    if (load)      cnt_nxt = '0;
    else if (step) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic              adv_n,
  input  logic              linear_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx
);
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              load, step;
  order_e            order;
  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] base_q, base_nxt, low_nxt, low_q;
  logic [BEAT_W-1:0] cnt_q, cnt_nxt;

  assign load     = !strb_a_n || !strb_b_n;
  assign step     = !adv_n && !load;
  assign order    = order_e'(linear_n);
  assign base_nxt = load ? addr_in[BEAT_W-1:0] : base_q;

  burst_beat_ctr #(.W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  burst_order_map #(.W(BEAT_W)) u_map (
    .order(order), .base(base_nxt), .idx(cnt_nxt), .low(low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      low_q  <= '0;
    end else begin
      if (load) hi_q <= addr_in[ADDR_W-1:BEAT_W];
      base_q <= base_nxt;
      low_q  <= low_nxt;
    end
  end

  assign addr_out = {hi_q, low_q};
  assign beat_idx = cnt_q;

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(addr_out) && $stable(beat_idx));

  // R3
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  // R1
  reset_val_chk: assert property (@(posedge clk)
    $past(rst) |-> (addr_out == '0) && (beat_idx == 2'd0));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb_a_n = 1'b1, strb_b_n = 1'b1, adv_n = 1'b1, linear_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_idx;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] q_addr[$];
  logic [1:0]    q_beat[$];
  string         q_tag[$];

  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
    .adv_n(adv_n), .linear_n(linear_n), .addr_in(addr_in),
    .addr_out(addr_out), .beat_idx(beat_idx)
  );

  task automatic drive(input logic sa, input logic sb, input logic adv,
                       input logic [AW-1:0] a, input string tag);
    logic [1:0] lo;
    @(negedge clk);
    strb_a_n = sa; strb_b_n = sb; adv_n = adv; addr_in = a;
    if (!sa || !sb) begin
      m_start = a;
      m_beat  = 2'd0;
    end else if (!adv) begin
      m_beat = m_beat + 2'd1;
    end
    lo = linear_n ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
    q_addr.push_back({m_start[AW-1:2], lo});
    q_beat.push_back(m_beat);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_addr.size() > 0) begin
      logic [AW-1:0] ea;
      logic [1:0]    eb;
      string         t;
      ea = q_addr.pop_front();
      eb = q_beat.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (addr_out !== ea || beat_idx !== eb) begin
        failures++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 t, addr_out, beat_idx, ea, eb);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (addr_out !== '0 || beat_idx !== 2'd0) begin
      failures++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", addr_out, beat_idx);
    end
    rst = 1'b0;
    // R1: first cycle after reset, idle inputs
    q_addr.push_back('0); q_beat.push_back(2'd0); q_tag.push_back("R1");

    for (int mode = 0; mode < 2; mode++) begin
      @(negedge clk);
      linear_n = mode[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {18'(20'h0A5C3 + s * 20'h111 + mode * 20'h777), 2'(s)};
        // R2 / R8: load by strobe A (or B) while stepping is also requested
        if (s[0]) drive(1'b1, 1'b0, 1'b0, a, "R2_R8");
        else      drive(1'b0, 1'b1, 1'b0, a, "R2_R8");
        drive(1'b1, 1'b1, 1'b0, '0, mode ? "R5" : "R4");
        drive(1'b1, 1'b1, 1'b1, '1, "R6");
        drive(1'b1, 1'b1, 1'b1, '0, "R6");
        drive(1'b1, 1'b1, 1'b0, '1, mode ? "R5_R3" : "R4_R3");
        drive(1'b1, 1'b1, 1'b0, '0, mode ? "R5" : "R4");
        drive(1'b1, 1'b1, 1'b0, '0, "R7");
        drive(1'b1, 1'b1, 1'b0, '0, "R7");
      end
      // R8: reload in the middle of a burst
      drive(1'b0, 1'b1, 1'b1, 20'hF0F01, "R2");
      drive(1'b1, 1'b1, 1'b0, '0, "R7");
      drive(1'b1, 1'b0, 1'b0, 20'h3C3C2, "R8");
      drive(1'b1, 1'b1, 1'b0, '0, mode ? "R5" : "R4");
      drive(1'b0, 1'b0, 1'b1, 20'h12343, "R2");
      drive(1'b1, 1'b1, 1'b0, '0, mode ? "R5" : "R4");
    end
    drive(1'b1, 1'b1, 1'b1, '0, "R6");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule